// File: doc/BRIEF.md
# Tiled-View Address Generator

This block converts a pixel coordinate into an address inside a two-dimensional tiled container. The caller gives an element format (8-bit, 16-bit, 32-bit or page mode), a 3-bit view orientation and the X and Y coordinates. The block returns the composed address and the row stride that goes with that format and orientation. The eight orientations are built from three independent controls: mirror X, mirror Y and swap the axes. Together these give the four rotations, each with or without mirroring.

The element format sets how many coordinate bits exist on each axis. It also sets how far the linear index moves up inside the address, so that every format fills the same index field. A coordinate beyond the range of its axis gives an all-zero address. The datapath is purely combinational up to a single output register. A request is accepted every cycle, and the result appears one cycle later. There is no back-pressure.

Top module: `tva_addr_gen`

## Requirements
- R1: The address word holds the orientation code in bits [31:29] and the format code in bits [28:27]. The format code is 0 for 8-bit, 1 for 16-bit, 2 for 32-bit and 3 for page mode. The shifted linear index fills bits [26:0].
- R2: Orientation bit 0 mirrors X by XORing it with the X-axis mask. Orientation bit 1 mirrors Y by XORing it with the Y-axis mask.
- R3: When orientation bit 2 is set, the index is (X shifted left by the Y width) plus Y. When bit 2 is clear, the index is (Y shifted left by the X width) plus X.
- R4: Each format has an X shift and a Y shift: 8-bit (0,0), 16-bit (0,1), 32-bit (1,1) and page mode (6,6). The X width is 14 minus the X shift, and the Y width is 13 minus the Y shift.
- R5: The index is shifted left by the sum of the two format shifts before it is placed in bits [26:0].
- R6: If X or Y is larger than its axis mask, the whole 32-bit address is 0.
- R7: When orientation bit 2 is set, the stride is 1 shifted left by (13 plus the X shift). When bit 2 is clear, the stride is 1 shifted left by (14 plus the Y shift). The stride does not depend on whether the coordinate is in range.
- R8: out_vld equals in_vld from the previous clock edge, so there is one cycle of latency.
- R9: While in_vld is low, out_addr and out_stride keep their last values.
- R10: A synchronous active-high reset clears out_vld, out_addr and out_stride to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Request strobe |
| in_fmt | input | 2 | Element format code |
| in_orient | input | 3 | View orientation code (bit0 mirror X, bit1 mirror Y, bit2 swap) |
| in_x | input | 14 | X coordinate in elements |
| in_y | input | 13 | Y coordinate in elements |
| out_vld | output | 1 | Result strobe, one cycle after in_vld |
| out_addr | output | 32 | Composed tiled address, 0 when out of range |
| out_stride | output | 32 | Row stride in bytes for the format and orientation |

## Verification
The properties assume a defined format and orientation code on every cycle with in_vld high. They also assume that inputs change only between clock edges. The field checks compare the registered address against the previous cycle's request, and so depend on that request being free of X. The bench drives every input at the falling edge from a fixed vector table. It never leaves a code undefined while the strobe is high, and it covers each format, each mirror and swap bit, and coordinates on both sides of each axis limit.

// File: rtl/tva_pkg.sv
package tva_pkg;

    // Default container geometry (in address bits)
    localparam int CONT_W_BITS = 14;
    localparam int CONT_H_BITS = 13;
    localparam int SLOT_W_BITS = 6;
    localparam int SLOT_H_BITS = 6;

    // Width of every shift amount carried through the datapath
    localparam int SHW = 5;
    typedef logic [SHW-1:0] tva_sh_t;

    // Element format codes; the value is placed in the address word
    typedef enum logic [1:0] {
        FMT_8B   = 2'd0,
        FMT_16B  = 2'd1,
        FMT_32B  = 2'd2,
        FMT_PAGE = 2'd3
    } tva_fmt_e;

    // Orientation controls; bit order matches the orientation code
    typedef struct packed {
        logic swap;   // bit 2
        logic y_inv;  // bit 1
        logic x_inv;  // bit 0
    } tva_orient_t;

    // Horizontal shift of a format
    function automatic tva_sh_t fmt_xshift(tva_fmt_e f, tva_sh_t slot_w);
        case (f)
            FMT_32B:  return tva_sh_t'(1);
            FMT_PAGE: return slot_w;
            default:  return tva_sh_t'(0);
        endcase
    endfunction

    // Vertical shift of a format
    function automatic tva_sh_t fmt_yshift(tva_fmt_e f, tva_sh_t slot_h);
        case (f)
            FMT_16B,
            FMT_32B:  return tva_sh_t'(1);
            FMT_PAGE: return slot_h;
            default:  return tva_sh_t'(0);
        endcase
    endfunction

endpackage

// File: rtl/tva_geom.sv
// Format decode: per-axis shifts, usable widths and coordinate masks.
module tva_geom
    import tva_pkg::*;
#(
    parameter int CW_BITS = CONT_W_BITS,
    parameter int CH_BITS = CONT_H_BITS,
    parameter int SW_BITS = SLOT_W_BITS,
    parameter int SH_BITS = SLOT_H_BITS
) (
    input  tva_fmt_e             fmt,
    output tva_sh_t              x_shift,
    output tva_sh_t              y_shift,
    output tva_sh_t              x_width,
    output tva_sh_t              y_width,
    output logic [CW_BITS-1:0]   x_mask,
    output logic [CH_BITS-1:0]   y_mask
);
    localparam tva_sh_t CW_SH = tva_sh_t'(CW_BITS);
    localparam tva_sh_t CH_SH = tva_sh_t'(CH_BITS);
    localparam tva_sh_t SW_SH = tva_sh_t'(SW_BITS);
    localparam tva_sh_t SH_SH = tva_sh_t'(SH_BITS);

    always_comb begin
        x_shift = fmt_xshift(fmt, SW_SH);
        y_shift = fmt_yshift(fmt, SH_SH);
        x_width = CW_SH - x_shift;
        y_width = CH_SH - y_shift;
        x_mask  = {CW_BITS{1'b1}} >> x_shift;
        y_mask  = {CH_BITS{1'b1}} >> y_shift;
    end
endmodule

// File: rtl/tva_index.sv
// Range check, per-axis mirroring and axis swap into a linear index.
module tva_index
    import tva_pkg::*;
#(
    parameter int CW_BITS = CONT_W_BITS,
    parameter int CH_BITS = CONT_H_BITS,
    localparam int IDX_W  = CW_BITS + CH_BITS
) (
    input  logic [CW_BITS-1:0] x,
    input  logic [CH_BITS-1:0] y,
    input  tva_orient_t        orient,
    input  tva_sh_t            x_width,
    input  tva_sh_t            y_width,
    input  logic [CW_BITS-1:0] x_mask,
    input  logic [CH_BITS-1:0] y_mask,
    output logic [IDX_W-1:0]   index,
    output logic               in_range
);
    logic [CW_BITS-1:0] x_view;
    logic [CH_BITS-1:0] y_view;
    logic               x_ok;
    logic               y_ok;

    always_comb begin
        x_ok     = (x & ~x_mask) == '0;
        y_ok     = (y & ~y_mask) == '0;
        in_range = x_ok && y_ok;

        x_view = orient.x_inv ? (x ^ x_mask) : x;
        y_view = orient.y_inv ? (y ^ y_mask) : y;

        if (orient.swap)
            index = (IDX_W'(x_view) << y_width) | IDX_W'(y_view);
        else
            index = (IDX_W'(y_view) << x_width) | IDX_W'(x_view);
    end
endmodule

// File: rtl/tva_compose.sv
// Aligns the index, merges the code fields and derives the row stride.
module tva_compose
    import tva_pkg::*;
#(
    parameter int CW_BITS  = CONT_W_BITS,
    parameter int CH_BITS  = CONT_H_BITS,
    parameter int STRIDE_W = 32,
    localparam int IDX_W   = CW_BITS + CH_BITS,
    localparam int ADDR_W  = IDX_W + 5
) (
    input  logic [IDX_W-1:0]    index,
    input  logic                in_range,
    input  tva_sh_t             x_shift,
    input  tva_sh_t             y_shift,
    input  tva_fmt_e            fmt,
    input  tva_orient_t         orient,
    output logic [ADDR_W-1:0]   addr,
    output logic [STRIDE_W-1:0] stride
);
    localparam logic [SHW+1:0] CW_EXP = (SHW+2)'(CW_BITS);
    localparam logic [SHW+1:0] CH_EXP = (SHW+2)'(CH_BITS);

    logic [SHW:0]       align;
    logic [SHW+1:0]     s_exp;
    logic [IDX_W-1:0]   aligned;

    always_comb begin
        align   = {1'b0, x_shift} + {1'b0, y_shift};
        aligned = index << align;
        addr    = in_range ? {orient, fmt, aligned} : '0;

        if (orient.swap)
            s_exp = CH_EXP + {2'b00, x_shift};
        else
            s_exp = CW_EXP + {2'b00, y_shift};
        stride = {{(STRIDE_W-1){1'b0}}, 1'b1} << s_exp;
    end
endmodule

// File: rtl/tva_addr_gen.sv
// Top: format decode, index build, composition and one output register.
module tva_addr_gen
    import tva_pkg::*;
#(
    parameter int CW_BITS  = CONT_W_BITS,
    parameter int CH_BITS  = CONT_H_BITS,
    parameter int SW_BITS  = SLOT_W_BITS,
    parameter int SH_BITS  = SLOT_H_BITS,
    parameter int STRIDE_W = 32,
    localparam int IDX_W   = CW_BITS + CH_BITS,
    localparam int ADDR_W  = IDX_W + 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_vld,
    input  logic [1:0]          in_fmt,
    input  logic [2:0]          in_orient,
    input  logic [CW_BITS-1:0]  in_x,
    input  logic [CH_BITS-1:0]  in_y,
    output logic                out_vld,
    output logic [ADDR_W-1:0]   out_addr,
    output logic [STRIDE_W-1:0] out_stride
);
    tva_fmt_e           fmt;
    tva_orient_t        orient;
    tva_sh_t            x_shift, y_shift, x_width, y_width;
    logic [CW_BITS-1:0] x_mask;
    logic [CH_BITS-1:0] y_mask;
    logic [IDX_W-1:0]   index;
    logic               in_range;
    logic [ADDR_W-1:0]  addr_nxt;
    logic [STRIDE_W-1:0] stride_nxt;

    assign fmt    = tva_fmt_e'(in_fmt);
    assign orient = tva_orient_t'(in_orient);

    tva_geom #(
        .CW_BITS(CW_BITS), .CH_BITS(CH_BITS),
        .SW_BITS(SW_BITS), .SH_BITS(SH_BITS)
    ) u_geom (
        .fmt(fmt), .x_shift(x_shift), .y_shift(y_shift),
        .x_width(x_width), .y_width(y_width),
        .x_mask(x_mask), .y_mask(y_mask)
    );

    tva_index #(.CW_BITS(CW_BITS), .CH_BITS(CH_BITS)) u_index (
        .x(in_x), .y(in_y), .orient(orient),
        .x_width(x_width), .y_width(y_width),
        .x_mask(x_mask), .y_mask(y_mask),
        .index(index), .in_range(in_range)
    );

    tva_compose #(
        .CW_BITS(CW_BITS), .CH_BITS(CH_BITS), .STRIDE_W(STRIDE_W)
    ) u_compose (
        .index(index), .in_range(in_range),
        .x_shift(x_shift), .y_shift(y_shift),
        .fmt(fmt), .orient(orient),
        .addr(addr_nxt), .stride(stride_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld    <= 1'b0;
            out_addr   <= '0;
            out_stride <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) begin
                out_addr   <= addr_nxt;
                out_stride <= stride_nxt;
            end
        end
    end
endmodule

// File: rtl/tva_addr_gen_chk.sv
// Property checker attached to the top by bind.
module tva_addr_gen_chk #(
    parameter int CW_BITS  = 14,
    parameter int CH_BITS  = 13,
    parameter int SW_BITS  = 6,
    parameter int SH_BITS  = 6,
    parameter int STRIDE_W = 32,
    localparam int IDX_W   = CW_BITS + CH_BITS,
    localparam int ADDR_W  = IDX_W + 5
) (
    input logic                clk,
    input logic                rst,
    input logic                in_vld,
    input logic [1:0]          in_fmt,
    input logic [2:0]          in_orient,
    input logic [CW_BITS-1:0]  in_x,
    input logic [CH_BITS-1:0]  in_y,
    input logic                out_vld,
    input logic [ADDR_W-1:0]   out_addr,
    input logic [STRIDE_W-1:0] out_stride
);
    localparam int PX_W = CW_BITS - SW_BITS;
    localparam int PY_W = CH_BITS - SH_BITS;

    // R8: one-cycle valid latency
    p_vld_follow_r8: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    p_vld_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);

    // R9: outputs hold while no request
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(out_addr) && $stable(out_stride)));

    // R1: code fields carry the request's orientation and format
    p_fields_r1: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> (out_addr == '0 ||
                    (out_addr[ADDR_W-1 -: 3] == $past(in_orient) &&
                     out_addr[ADDR_W-4 -: 2] == $past(in_fmt))));

    // R7: stride is always a single power of two after a request
    p_stride_pow2_r7: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> $countones(out_stride) == 1);

    // R6: page-mode coordinate past its axis range gives zero
    p_page_range_r6: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_fmt == 2'd3 &&
         ((in_x >> PX_W) != '0 || (in_y >> PY_W) != '0))
        |=> out_addr == '0);

    // R5: 32-bit format leaves the two lowest index bits clear
    p_align_r5: assert property (@(posedge clk) disable iff (rst)
        (in_vld && in_fmt == 2'd2) |=> out_addr[1:0] == 2'b00);

    // R10: reset clears the result strobe
    p_reset_r10: assert property (@(posedge clk)
        rst |=> !out_vld);
endmodule

bind tva_addr_gen tva_addr_gen_chk #(
    .CW_BITS(CW_BITS), .CH_BITS(CH_BITS),
    .SW_BITS(SW_BITS), .SH_BITS(SH_BITS), .STRIDE_W(STRIDE_W)
) u_chk (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_fmt(in_fmt),
    .in_orient(in_orient), .in_x(in_x), .in_y(in_y),
    .out_vld(out_vld), .out_addr(out_addr), .out_stride(out_stride)
);

// File: tb/test_tva_addr_gen.sv
`timescale 1ns/1ps
module test_tva_addr_gen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_vld = 1'b0;
    logic [1:0]  in_fmt = '0;
    logic [2:0]  in_orient = '0;
    logic [13:0] in_x = '0;
    logic [12:0] in_y = '0;
    logic        out_vld;
    logic [31:0] out_addr;
    logic [31:0] out_stride;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    tva_addr_gen i_tva_addr_gen (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_fmt(in_fmt),
        .in_orient(in_orient), .in_x(in_x), .in_y(in_y),
        .out_vld(out_vld), .out_addr(out_addr), .out_stride(out_stride)
    );

    typedef struct packed {
        logic [1:0]  f;
        logic [2:0]  o;
        logic [13:0] x;
        logic [12:0] y;
        logic [31:0] a;
        logic [31:0] s;
    } vec_t;

    localparam int NV = 12;
    // Expected values worked out by hand from R1..R7
    localparam vec_t VEC [NV] = '{
        '{2'd0, 3'd0, 14'h0005, 13'h0003, 32'h0000C005, 32'h00004000}, // R1 R4 plain 8-bit
        '{2'd0, 3'd3, 14'h0005, 13'h0003, 32'h67FF3FFA, 32'h00004000}, // R2 both mirrors
        '{2'd1, 3'd4, 14'h0010, 13'h0020, 32'h88020040, 32'h00002000}, // R3 swap, 16-bit
        '{2'd2, 3'd0, 14'h0100, 13'h0002, 32'h10010400, 32'h00008000}, // R5 32-bit align
        '{2'd3, 3'd0, 14'h0001, 13'h0001, 32'h18101000, 32'h00100000}, // R4 page mode
        '{2'd3, 3'd7, 14'h00FF, 13'h007F, 32'hF8000000, 32'h00080000}, // R2 page max mirrored
        '{2'd3, 3'd0, 14'h0100, 13'h0000, 32'h00000000, 32'h00100000}, // R6 page X over
        '{2'd2, 3'd2, 14'h1FFF, 13'h1000, 32'h00000000, 32'h00008000}, // R6 32-bit Y over
        '{2'd1, 3'd1, 14'h0000, 13'h0FFF, 32'h2FFFFFFE, 32'h00008000}, // R2 X mirror, Y at limit
        '{2'd0, 3'd6, 14'h3FFF, 13'h0000, 32'hC7FFFFFF, 32'h00002000}, // R3 swap + Y mirror
        '{2'd2, 3'd5, 14'h0003, 13'h0004, 32'hB7FF0010, 32'h00004000}, // R7 swap stride 32-bit
        '{2'd3, 3'd0, 14'h0000, 13'h0080, 32'h00000000, 32'h00100000}  // R6 page Y over
    };
    localparam string TAG [NV] = '{"R1", "R2", "R3", "R5", "R4", "R2",
                                   "R6", "R6", "R2", "R3", "R7", "R6"};

    task automatic check32(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        // R10: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check32("R10", "out_vld in reset", {31'b0, out_vld}, 32'd0);
        check32("R10", "out_addr in reset", out_addr, 32'd0);
        check32("R10", "out_stride in reset", out_stride, 32'd0);
        rst = 1'b0;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            in_vld    = 1'b1;
            in_fmt    = VEC[i].f;
            in_orient = VEC[i].o;
            in_x      = VEC[i].x;
            in_y      = VEC[i].y;
            @(posedge clk);
            @(negedge clk);
            check32("R8", "out_vld after request", {31'b0, out_vld}, 32'd1);
            check32(TAG[i], $sformatf("addr vec %0d", i), out_addr, VEC[i].a);
            check32("R7", $sformatf("stride vec %0d", i), out_stride, VEC[i].s);
        end

        // R9 / R8: new inputs without strobe must not change outputs
        in_vld    = 1'b0;
        in_fmt    = 2'd0;
        in_orient = 3'd0;
        in_x      = 14'h0005;
        in_y      = 13'h0003;
        @(posedge clk);
        @(negedge clk);
        check32("R8", "out_vld idle", {31'b0, out_vld}, 32'd0);
        check32("R9", "addr held", out_addr, 32'h0);
        check32("R9", "stride held", out_stride, 32'h00100000);

        // R8: strobe for exactly one cycle
        in_vld = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_vld = 1'b0;
        check32("R8", "single strobe out", {31'b0, out_vld}, 32'd1);
        check32("R1", "single strobe addr", out_addr, 32'h0000C005);
        @(posedge clk);
        @(negedge clk);
        check32("R8", "strobe drops", {31'b0, out_vld}, 32'd0);

        // R10: reset mid-run clears outputs
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check32("R10", "addr after reset", out_addr, 32'd0);
        check32("R10", "stride after reset", out_stride, 32'd0);
        rst = 1'b0;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule